// File: doc/BRIEF.md
# Machine-Mode Control Register Bank with Write Legalization

This block holds the machine-level control and status registers of a 64-bit core. Each register sits at a 12-bit address. Software writes a register by presenting the address, the data and a one-cycle write strobe. The read port is combinational: it returns the value held at whatever address is currently presented. An illegal-access flag rises whenever that address is not implemented.

Writes are not stored blindly. Each register has its own filter between the write data and its flops, so a field can never take an encoding the core does not support. Depending on the register and the field, the filter forces a value, keeps the old contents, or accepts the new value only when its encoding is legal. The scratch, exception-PC, cause and trap-value registers have no filter and store what is written. The ISA-description register is a constant and ignores writes.

Top module: `mcsr_bank`

## Requirements
- R1: The registers are at these addresses: status 0x300, ISA description 0x301, exception delegation 0x302, interrupt delegation 0x303, interrupt enable 0x304, trap vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342, trap value 0x343 and interrupt pending 0x344. Scratch, exception PC, cause (interrupt flag in bit 63, code in bits 62:0) and trap value store the full 64-bit written value and read it back unchanged.
- R2: On a status write, the extension-state field (bits 16:15) is forced to Off (0). Bit 63 is recomputed as the OR of "float-state field (bits 14:13) equals Dirty (3)" and "extension-state field equals Dirty". The written bit 63 is ignored.
- R3: On a status write, the register-width fields (bits 35:34 and 33:32) keep their previous contents. The user interrupt-enable bit (bit 0) and the user previous-enable bit (bit 4) are forced to 0. All other status bits take the written value.
- R4: On an interrupt-pending write, only bits 1, 5 and 9 (supervisor software, timer and external) take new values. All other bits keep their old values.
- R5: On an interrupt-enable write, only bits 1, 3, 5, 7, 9 and 11 (supervisor and machine software, timer and external) take new values. All other bits keep their old values.
- R6: An interrupt-delegation write is stored unchanged. An exception-delegation write is stored with bit 11 (machine environment call) forced to 0.
- R7: The trap vector holds a base in bits 63:2 and a mode in bits 1:0, where 0 means direct and 1 means vectored. A write with mode 0 or 1 is stored whole. Any other mode keeps the old mode, and the base is still updated.
- R8: Address 0x301 reads the constant parameter value (default 0x8000_0000_0014_1101), and writes to it have no effect.
- R9: A read of an unimplemented address returns zero with the illegal flag high. A write to such an address changes no register.
- R10: After synchronous reset, every register reads zero, except status, which reads 0x0000_000A_0000_0000 (both width fields set to 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address for both the read and the write |
| wr_en | input | 1 | Write strobe, sampled at the rising clock edge |
| wr_data | input | 64 | Write data before legalization |
| rd_data | output | 64 | Combinational read data for csr_addr |
| illegal | output | 1 | High when csr_addr is not an implemented register |

## Verification
The assertions assume that the write strobe, address and data are stable around each rising edge. They also assume that reset is held for at least two cycles at power-up, so that every stability property has a defined previous value. The bench drives all inputs on the falling edge and holds reset for several cycles. It checks reads one time unit after it changes the address, because the read path has no register and the result is ready well before the next rising edge. Every legalization rule is checked with all-ones and all-zeros patterns, and with selected single fields, so that both the forced values and the kept values can be seen.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN = 64;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_IDELEG  = 12'h303;
  localparam logic [11:0] A_IEN     = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IPEND   = 12'h344;

  // status field positions
  localparam int ST_UIE  = 0;
  localparam int ST_UPIE = 4;
  localparam int ST_FS   = 13;
  localparam int ST_XS   = 15;
  localparam int ST_UXL  = 32;
  localparam int ST_SXL  = 34;
  localparam int ST_SD   = 63;

  // interrupt bit positions
  localparam int IRQ_SS = 1;
  localparam int IRQ_MS = 3;
  localparam int IRQ_ST = 5;
  localparam int IRQ_MT = 7;
  localparam int IRQ_SE = 9;
  localparam int IRQ_ME = 11;

  localparam int EXC_MECALL = 11;

  typedef enum logic [1:0] {
    XST_OFF   = 2'd0,
    XST_INIT  = 2'd1,
    XST_CLEAN = 2'd2,
    XST_DIRTY = 2'd3
  } xstate_e;

  typedef enum logic [1:0] {
    TVM_DIRECT   = 2'd0,
    TVM_VECTORED = 2'd1
  } tvmode_e;

  localparam logic [1:0] XL_64 = 2'd2;

  localparam logic [XLEN-1:0] IPEND_WMASK =
    (64'd1 << IRQ_SS) | (64'd1 << IRQ_ST) | (64'd1 << IRQ_SE);
  localparam logic [XLEN-1:0] IEN_WMASK = IPEND_WMASK |
    (64'd1 << IRQ_MS) | (64'd1 << IRQ_MT) | (64'd1 << IRQ_ME);
  localparam logic [XLEN-1:0] EDELEG_ZMASK = 64'd1 << EXC_MECALL;
  localparam logic [XLEN-1:0] STATUS_RST =
    ({62'd0, XL_64} << ST_SXL) | ({62'd0, XL_64} << ST_UXL);
endpackage

// File: rtl/mcsr_status_legal.sv
module mcsr_status_legal
  import mcsr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [3:0]   old_xl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] new_val
);
  logic fs_dirty;
  logic xs_dirty;

  always_comb begin
    new_val             = wdata;
    new_val[ST_XS +: 2] = XST_OFF;
    new_val[ST_UXL +: 4] = old_xl;
    new_val[ST_UPIE]    = 1'b0;
    new_val[ST_UIE]     = 1'b0;
    fs_dirty            = (new_val[ST_FS +: 2] == XST_DIRTY);
    xs_dirty            = (new_val[ST_XS +: 2] == XST_DIRTY);
    new_val[ST_SD]      = fs_dirty | xs_dirty;
  end
endmodule

// File: rtl/mcsr_field_merge.sv
module mcsr_field_merge #(
  parameter int           W      = 64,
  parameter logic [W-1:0] WMASK  = '1,
  parameter logic [W-1:0] ZMASK  = '0
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] new_val
);
  always_comb begin
    new_val = ((old_val & ~WMASK) | (wdata & WMASK)) & ~ZMASK;
  end
endmodule

// File: rtl/mcsr_tvec_legal.sv
module mcsr_tvec_legal
  import mcsr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [1:0]   old_mode,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] new_val
);
  logic mode_ok;

  always_comb begin
    mode_ok = (wdata[1:0] == TVM_DIRECT) || (wdata[1:0] == TVM_VECTORED);
    new_val = wdata;
    if (!mode_ok) new_val[1:0] = old_mode;
  end
endmodule

// File: rtl/mcsr_bank.sv
module mcsr_bank
  import mcsr_pkg::*;
#(
  parameter int               W       = XLEN,
  parameter int               AW      = 12,
  parameter logic [XLEN-1:0]  ISA_VAL = 64'h8000_0000_0014_1101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] csr_addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          illegal
);
  localparam int NREG = 10;
  typedef enum int {
    I_STATUS, I_EDELEG, I_IDELEG, I_IEN, I_TVEC,
    I_SCRATCH, I_EPC, I_CAUSE, I_TVAL, I_IPEND
  } ridx_e;

  logic [W-1:0] regs [NREG];
  logic [W-1:0] nxt  [NREG];
  logic [W-1:0] rst_val [NREG];
  logic [NREG-1:0] sel;
  logic         isa_hit;

  always_comb begin
    sel     = '0;
    isa_hit = 1'b0;
    case (csr_addr)
      A_STATUS:  sel[I_STATUS]  = 1'b1;
      A_ISA:     isa_hit        = 1'b1;
      A_EDELEG:  sel[I_EDELEG]  = 1'b1;
      A_IDELEG:  sel[I_IDELEG]  = 1'b1;
      A_IEN:     sel[I_IEN]     = 1'b1;
      A_TVEC:    sel[I_TVEC]    = 1'b1;
      A_SCRATCH: sel[I_SCRATCH] = 1'b1;
      A_EPC:     sel[I_EPC]     = 1'b1;
      A_CAUSE:   sel[I_CAUSE]   = 1'b1;
      A_TVAL:    sel[I_TVAL]    = 1'b1;
      A_IPEND:   sel[I_IPEND]   = 1'b1;
      default: ;
    endcase
  end

  mcsr_status_legal #(.W(W)) u_status (
    .old_xl (regs[I_STATUS][ST_UXL +: 4]),
    .wdata  (wr_data),
    .new_val(nxt[I_STATUS])
  );

  mcsr_field_merge #(.W(W), .WMASK('1), .ZMASK(EDELEG_ZMASK)) u_edeleg (
    .old_val(regs[I_EDELEG]), .wdata(wr_data), .new_val(nxt[I_EDELEG])
  );

  mcsr_field_merge #(.W(W), .WMASK('1), .ZMASK('0)) u_ideleg (
    .old_val(regs[I_IDELEG]), .wdata(wr_data), .new_val(nxt[I_IDELEG])
  );

  mcsr_field_merge #(.W(W), .WMASK(IEN_WMASK), .ZMASK('0)) u_ien (
    .old_val(regs[I_IEN]), .wdata(wr_data), .new_val(nxt[I_IEN])
  );

  mcsr_field_merge #(.W(W), .WMASK(IPEND_WMASK), .ZMASK('0)) u_ipend (
    .old_val(regs[I_IPEND]), .wdata(wr_data), .new_val(nxt[I_IPEND])
  );

  mcsr_tvec_legal #(.W(W)) u_tvec (
    .old_mode(regs[I_TVEC][1:0]),
    .wdata   (wr_data),
    .new_val (nxt[I_TVEC])
  );

  // unfiltered registers
  generate
    for (genvar g = I_SCRATCH; g <= I_TVAL; g++) begin : g_plain
      assign nxt[g] = wr_data;
    end
  endgenerate

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign rst_val[g] = (g == I_STATUS) ? STATUS_RST : '0;
      always_ff @(posedge clk) begin
        if (rst)                  regs[g] <= rst_val[g];
        else if (wr_en && sel[g]) regs[g] <= nxt[g];
      end
    end
  endgenerate

  always_comb begin
    rd_data = isa_hit ? ISA_VAL : '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd_data = rd_data | regs[i];
    illegal = ~(isa_hit | (|sel));
  end

  // named views for the checker
  logic [W-1:0] v_status, v_edeleg, v_ideleg, v_ien, v_tvec;
  logic [W-1:0] v_scratch, v_epc, v_cause, v_tval, v_ipend;
  assign v_status  = regs[I_STATUS];
  assign v_edeleg  = regs[I_EDELEG];
  assign v_ideleg  = regs[I_IDELEG];
  assign v_ien     = regs[I_IEN];
  assign v_tvec    = regs[I_TVEC];
  assign v_scratch = regs[I_SCRATCH];
  assign v_epc     = regs[I_EPC];
  assign v_cause   = regs[I_CAUSE];
  assign v_tval    = regs[I_TVAL];
  assign v_ipend   = regs[I_IPEND];
endmodule

// File: rtl/mcsr_chk.sv
module mcsr_chk
  import mcsr_pkg::*;
#(
  parameter int W = XLEN
) (
  input logic         clk,
  input logic         rst,
  input logic [11:0]  csr_addr,
  input logic         wr_en,
  input logic [W-1:0] rd_data,
  input logic         illegal,
  input logic [W-1:0] st,
  input logic [W-1:0] edeleg,
  input logic [W-1:0] ideleg,
  input logic [W-1:0] ien,
  input logic [W-1:0] tvec,
  input logic [W-1:0] scratch,
  input logic [W-1:0] epc,
  input logic [W-1:0] cause,
  input logic [W-1:0] tval,
  input logic [W-1:0] ipend
);
  AST_XS_OFF: assert property (@(posedge clk) disable iff (rst)
    st[ST_XS +: 2] == 2'd0); // R2
  AST_SD_MATCH: assert property (@(posedge clk) disable iff (rst)
    st[ST_SD] == ((st[ST_FS +: 2] == 2'd3) || (st[ST_XS +: 2] == 2'd3))); // R2
  AST_XL_HELD: assert property (@(posedge clk) disable iff (rst)
    $stable(st[ST_UXL +: 4])); // R3
  AST_UIE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !st[ST_UIE] && !st[ST_UPIE]); // R3
  AST_IPEND_MASK: assert property (@(posedge clk) disable iff (rst)
    (ipend & ~IPEND_WMASK) == '0); // R4
  AST_IEN_MASK: assert property (@(posedge clk) disable iff (rst)
    (ien & ~IEN_WMASK) == '0); // R5
  AST_ECALL_DELEG: assert property (@(posedge clk) disable iff (rst)
    !edeleg[EXC_MECALL]); // R6
  AST_TVEC_MODE: assert property (@(posedge clk) disable iff (rst)
    tvec[1] == 1'b0); // R7
  AST_ISA_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == A_ISA) |-> !illegal); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> rd_data == '0); // R9
  AST_ILLEGAL_NOWR: assert property (@(posedge clk) disable iff (rst)
    (illegal && wr_en) |=> ($stable(st) && $stable(edeleg) && $stable(ideleg)
      && $stable(ien) && $stable(tvec) && $stable(scratch) && $stable(epc)
      && $stable(cause) && $stable(tval) && $stable(ipend))); // R9
endmodule

bind mcsr_bank mcsr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr), .wr_en(wr_en),
  .rd_data(rd_data), .illegal(illegal),
  .st(v_status), .edeleg(v_edeleg), .ideleg(v_ideleg), .ien(v_ien),
  .tvec(v_tvec), .scratch(v_scratch), .epc(v_epc), .cause(v_cause),
  .tval(v_tval), .ipend(v_ipend)
);

// File: tb/sim_mcsr_bank.sv
`timescale 1ns/1ps
module sim_mcsr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] ISA_DEF = 64'h8000_0000_0014_1101;
  localparam logic [63:0] ONES    = '1;

  always #10 clk = ~clk;

  mcsr_bank u0 (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic ill);
    @(negedge clk);
    csr_addr = a;
    #1;
    d = rd_data; ill = illegal;
  endtask

  function automatic logic [63:0] st_exp(input logic [63:0] w);
    logic [63:0] e;
    e = w;
    e[16:15] = 2'd0;
    e[35:32] = 4'hA;
    e[4] = 1'b0;
    e[0] = 1'b0;
    e[63] = (e[14:13] == 2'd3);
    return e;
  endfunction

  task automatic t_reset();
    logic [63:0] d; logic ill;
    rd(12'h300, d, ill); chk("R10 status reset", d, 64'h0000_000A_0000_0000);
    chk("R10 status legal", {63'd0, ill}, 64'd0);
    rd(12'h304, d, ill); chk("R10 enable reset", d, 64'd0);
    rd(12'h305, d, ill); chk("R10 tvec reset", d, 64'd0);
    rd(12'h340, d, ill); chk("R10 scratch reset", d, 64'd0);
  endtask

  task automatic t_plain();
    logic [63:0] d; logic ill;
    wr(12'h340, 64'hDEAD_BEEF_0123_4567); rd(12'h340, d, ill);
    chk("R1 scratch", d, 64'hDEAD_BEEF_0123_4567);
    wr(12'h341, ONES); rd(12'h341, d, ill); chk("R1 epc", d, ONES);
    wr(12'h342, 64'h8000_0000_0000_0007); rd(12'h342, d, ill);
    chk("R1 cause", d, 64'h8000_0000_0000_0007);
    wr(12'h343, 64'h0000_1234_5678_9ABC); rd(12'h343, d, ill);
    chk("R1 tval", d, 64'h0000_1234_5678_9ABC);
    rd(12'h340, d, ill); chk("R1 scratch kept", d, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_status();
    logic [63:0] d; logic ill;
    wr(12'h300, ONES); rd(12'h300, d, ill); chk("R2 R3 status ones", d, st_exp(ONES));
    wr(12'h300, 64'h8000_0000_0000_0000); rd(12'h300, d, ill);
    chk("R2 sd ignored", d, 64'h0000_000A_0000_0000);
    wr(12'h300, 64'h0000_0000_0001_C000); rd(12'h300, d, ill);
    chk("R2 xs dirty forced off", d, 64'h0000_000A_0000_4000);
    wr(12'h300, 64'h0000_0005_0000_0011); rd(12'h300, d, ill);
    chk("R3 xl kept uie cleared", d, 64'h0000_000A_0000_0000);
  endtask

  task automatic t_irq();
    logic [63:0] d; logic ill;
    wr(12'h344, ONES); rd(12'h344, d, ill); chk("R4 pending ones", d, 64'h222);
    wr(12'h344, 64'h0); rd(12'h344, d, ill); chk("R4 pending zero", d, 64'h0);
    wr(12'h304, ONES); rd(12'h304, d, ill); chk("R5 enable ones", d, 64'hAAA);
    wr(12'h304, 64'h555); rd(12'h304, d, ill); chk("R5 enable odd mask", d, 64'h0);
    wr(12'h304, 64'h8); rd(12'h304, d, ill); chk("R5 enable msi", d, 64'h8);
  endtask

  task automatic t_deleg();
    logic [63:0] d; logic ill;
    wr(12'h303, ONES); rd(12'h303, d, ill); chk("R6 ideleg", d, ONES);
    wr(12'h302, ONES); rd(12'h302, d, ill); chk("R6 edeleg", d, ~(64'd1 << 11));
  endtask

  task automatic t_tvec();
    logic [63:0] d; logic ill;
    wr(12'h305, 64'h1001); rd(12'h305, d, ill); chk("R7 vectored", d, 64'h1001);
    wr(12'h305, 64'h2002); rd(12'h305, d, ill); chk("R7 mode2 kept", d, 64'h2001);
    wr(12'h305, 64'h3003); rd(12'h305, d, ill); chk("R7 mode3 kept", d, 64'h3001);
    wr(12'h305, 64'h4000); rd(12'h305, d, ill); chk("R7 direct", d, 64'h4000);
  endtask

  task automatic t_isa_unimpl();
    logic [63:0] d; logic ill;
    rd(12'h301, d, ill); chk("R8 isa read", d, ISA_DEF);
    wr(12'h301, 64'h0); rd(12'h301, d, ill); chk("R8 isa write ignored", d, ISA_DEF);
    rd(12'h7C0, d, ill); chk("R9 unimpl data", d, 64'h0);
    chk("R9 unimpl flag", {63'd0, ill}, 64'd1);
    wr(12'h7C0, ONES); rd(12'h340, d, ill);
    chk("R9 write no effect", d, 64'hDEAD_BEEF_0123_4567);
    rd(12'h305, d, ill); chk("R9 tvec untouched", d, 64'h4000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_status();
    t_irq();
    t_deleg();
    t_tvec();
    t_isa_unimpl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule